// File: doc/BRIEF.md
# Power-Management Event Register Block with SCI

This block collects power-management events into a 16-bit status register and lets software select which of them may interrupt through a 16-bit enable register. It drives a level-sensitive system control interrupt (SCI). Only four event kinds can assert the SCI: the PM timer overflow, the global lock release, the power button and the RTC alarm. Any other status bit is recorded but never interrupts.

Software reaches the two registers, and a free-running PM timer, through a 64-byte I/O window. The window base comes from a configuration dword and is forced to 64-byte alignment. A separate configuration enable bit switches decoding of the window on and off. The timer sets its status bit each time its most significant bit toggles. Hardware events arrive as one-cycle set pulses on a 16-bit event input.

Top module: `pm_evt_sci`

## Requirements
- R1: After reset the status and enable registers are 0, `sci` and `tmr_arm` are 0, the configuration dwords at index 0x10 (byte 0x40) and 0x20 (byte 0x80) read 0, the dword at index 0x12 (byte 0x48) reads 0x00000001, and the window is not decoded.
- R2: The window base is configuration dword 0x10 ANDed with 0xFFC0. `io_hit` is 1 exactly for addresses from the base to the base plus 63, and the written dword reads back unchanged.
- R3: The window is decoded only while bit 0 of configuration dword 0x20 is 1. While that bit is 0, `io_hit` and `io_rdata` are 0 and I/O writes change no register.
- R4: A 1 on bit n of `evt_in` at a clock edge sets status bit n, and the bit stays set until software clears it.
- R5: A status bit is cleared by writing 1 to it at window offset 0x00. Writing 0 leaves the bit unchanged. An event and a clear on the same bit in the same cycle leave the bit set.
- R6: Status reads at window offset 0x00 and enable at offset 0x02, as 16-bit words. The enable register is fully read/write. Any other offset in the window reads 0 and ignores writes, except the timer offsets.
- R7: `sci` is 1 while any of status bits 0 (timer), 5 (global lock), 8 (power button) or 10 (RTC) is set together with its enable bit. A set and enabled status bit at any other position does not assert `sci`.
- R8: `sci` is a level. It stays 1 while its condition holds and is 0 right after the clock edge that clears either the status bit or the enable bit behind it.
- R9: The PM timer is a TMR_W-bit counter that starts at 0 after reset and adds 1 every cycle. It reads at offset 0x08 (bits 15:0) and 0x0A (bits 31:16, zero-extended). Status bit 0 sets at the edge where counter bit TMR_W-1 toggles.
- R10: `tmr_arm` is 1 exactly while enable bit 0 is 1 and status bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration dword write strobe |
| cfg_dw_addr | input | 6 | Configuration dword index (byte offset / 4) |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_dw_addr` |
| io_wr | input | 1 | I/O word write strobe |
| io_rd | input | 1 | I/O word read strobe |
| io_addr | input | 16 | I/O byte address |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 16 | I/O read data, 0 when the access misses |
| io_hit | output | 1 | Address falls in the enabled window |
| evt_in | input | 16 | Per-bit status set pulses |
| sci | output | 1 | System control interrupt level |
| tmr_arm | output | 1 | Timer overflow event armed |

## Verification
All register updates take effect at the clock edge that samples a write or an event. Reads, `io_hit`, `sci` and `tmr_arm` are combinational from the registers. A register result is therefore due one edge after the stimulus, and a read is valid within the same cycle it is presented. The bench drives every input on the falling edge and samples a nanosecond later. A write or event is checked on the falling edge that follows the rising edge that took it in. The timer's status bit is checked by polling the counter. When the count reaches the all-ones value below the MSB toggle, status bit 0 must still be clear, and it must be set exactly one cycle later.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

    localparam int REG_W = 16;

    localparam int BIT_TMR    = 0;
    localparam int BIT_GLOBAL = 5;
    localparam int BIT_PWRBTN = 8;
    localparam int BIT_RTC    = 10;

    localparam logic [REG_W-1:0] SCI_SRC_MASK =
        (REG_W'(1) << BIT_TMR) | (REG_W'(1) << BIT_GLOBAL) |
        (REG_W'(1) << BIT_PWRBTN) | (REG_W'(1) << BIT_RTC);

    localparam int               WIN_BYTES      = 64;
    localparam logic [15:0]      WIN_ALIGN_MASK = ~16'(WIN_BYTES - 1);

    localparam logic [5:0]  CFG_DW_BASE = 6'h10;
    localparam logic [5:0]  CFG_DW_AUX  = 6'h12;
    localparam logic [5:0]  CFG_DW_CTRL = 6'h20;
    localparam logic [31:0] CFG_AUX_RST = 32'h0000_0001;

    localparam logic [5:0] OFF_STS    = 6'h00;
    localparam logic [5:0] OFF_EN     = 6'h02;
    localparam logic [5:0] OFF_TMR_LO = 6'h08;
    localparam logic [5:0] OFF_TMR_HI = 6'h0A;

    typedef enum logic [2:0] {
        SEL_STS,
        SEL_EN,
        SEL_TMR_LO,
        SEL_TMR_HI,
        SEL_NONE
    } win_sel_e;

    typedef struct packed {
        logic             wr;
        logic             rd;
        win_sel_e         sel;
        logic [REG_W-1:0] wdata;
    } win_acc_t;

    function automatic win_sel_e decode_offset(input logic [5:0] off);
        case (off)
            OFF_STS:    return SEL_STS;
            OFF_EN:     return SEL_EN;
            OFF_TMR_LO: return SEL_TMR_LO;
            OFF_TMR_HI: return SEL_TMR_HI;
            default:    return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
    import pm_evt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [5:0]  cfg_dw_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic [15:0] win_base,
    output logic        win_en
);

    logic [31:0] base_q;
    logic [31:0] aux_q;
    logic        ctrl_en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q    <= '0;
            aux_q     <= CFG_AUX_RST;
            ctrl_en_q <= 1'b0;
        end else if (cfg_wr) begin
            case (cfg_dw_addr)
                CFG_DW_BASE: base_q    <= cfg_wdata;
                CFG_DW_AUX:  aux_q     <= cfg_wdata;
                CFG_DW_CTRL: ctrl_en_q <= cfg_wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (cfg_dw_addr)
            CFG_DW_BASE: cfg_rdata = base_q;
            CFG_DW_AUX:  cfg_rdata = aux_q;
            CFG_DW_CTRL: cfg_rdata = {31'd0, ctrl_en_q};
            default:     cfg_rdata = '0;
        endcase
    end

    assign win_base = base_q[15:0] & WIN_ALIGN_MASK;
    assign win_en   = ctrl_en_q;

    // R1: the auxiliary dword returns to its initial value after reset
    p_aux_reset_r1: assert property (@(posedge clk)
        rst |=> (aux_q == CFG_AUX_RST));

    // R2: base alignment, low bits never reach the window
    p_base_aligned_r2: assert property (@(posedge clk) disable iff (rst)
        win_base[5:0] == 6'd0);

endmodule

// File: rtl/pm_win_decode.sv
module pm_win_decode
    import pm_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             io_wr,
    input  logic             io_rd,
    input  logic [15:0]      io_addr,
    input  logic [REG_W-1:0] io_wdata,
    input  logic [15:0]      win_base,
    input  logic             win_en,
    output logic             io_hit,
    output win_acc_t         acc
);

    always_comb begin
        io_hit    = win_en && ((io_addr & WIN_ALIGN_MASK) == win_base);
        acc.wr    = io_hit && io_wr;
        acc.rd    = io_hit && io_rd;
        acc.sel   = io_hit ? decode_offset(io_addr[5:0]) : SEL_NONE;
        acc.wdata = io_wdata;
    end

    // R3: no decode while the window is switched off
    p_window_off_r3: assert property (@(posedge clk) disable iff (rst)
        !win_en |-> !io_hit && !acc.wr && !acc.rd);

    // R2: a hit lies inside the 64-byte range starting at the base
    p_hit_range_r2: assert property (@(posedge clk) disable iff (rst)
        io_hit |-> (io_addr >= win_base) &&
                   ({1'b0, io_addr} < ({1'b0, win_base} + 17'(WIN_BYTES))));

endmodule

// File: rtl/pm_timer.sv
module pm_timer #(
    parameter int TMR_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    output logic [TMR_W-1:0] count,
    output logic             msb_toggle
);

    localparam int LOW_W = TMR_W - 1;

    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + TMR_W'(1);
    end

    assign count      = cnt_q;
    assign msb_toggle = &cnt_q[LOW_W-1:0];

    // R9: the counter steps by one every cycle
    p_tmr_step_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> cnt_q == $past(cnt_q) + TMR_W'(1));

    // R9: the toggle flag precedes a change of the MSB
    p_tmr_toggle_r9: assert property (@(posedge clk) disable iff (rst)
        msb_toggle |=> cnt_q[TMR_W-1] != $past(cnt_q[TMR_W-1]));

endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
    import pm_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  win_acc_t         acc,
    input  logic [REG_W-1:0] evt_in,
    input  logic             tmr_ovf,
    output logic [REG_W-1:0] sts,
    output logic [REG_W-1:0] en,
    output logic             sci,
    output logic             tmr_arm
);

    logic [REG_W-1:0] sts_q;
    logic [REG_W-1:0] en_q;
    logic [REG_W-1:0] clr_vec;
    logic [REG_W-1:0] set_vec;

    assign clr_vec = (acc.wr && acc.sel == SEL_STS) ? acc.wdata : '0;
    assign set_vec = evt_in | (REG_W'(tmr_ovf) << BIT_TMR);

    for (genvar i = 0; i < REG_W; i++) begin : g_sts
        always_ff @(posedge clk) begin
            if (rst)             sts_q[i] <= 1'b0;
            else if (set_vec[i]) sts_q[i] <= 1'b1;
            else if (clr_vec[i]) sts_q[i] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                               en_q <= '0;
        else if (acc.wr && acc.sel == SEL_EN)  en_q <= acc.wdata;
    end

    assign sts     = sts_q;
    assign en      = en_q;
    assign sci     = |(sts_q & en_q & SCI_SRC_MASK);
    assign tmr_arm = en_q[BIT_TMR] & ~sts_q[BIT_TMR];

    // R4: an event pulse leaves its status bit set
    p_evt_sets_r4: assert property (@(posedge clk) disable iff (rst)
        (evt_in != '0) |=> ((sts_q & $past(evt_in)) == $past(evt_in)));

    // R5: bits not written with 1 hold their value
    p_sts_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (sts_q != '0) |=> ((sts_q & $past(sts_q & ~clr_vec)) == $past(sts_q & ~clr_vec)));

    // R5: a bit only falls after a write of 1 to it
    p_sts_fall_r5: assert property (@(posedge clk) disable iff (rst)
        (sts_q != '0) |=> ((~sts_q & $past(sts_q)) & ~$past(clr_vec)) == '0);

endmodule

// File: rtl/pm_evt_sci.sv
module pm_evt_sci
    import pm_evt_pkg::*;
#(
    parameter int TMR_W = 24
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_wr,
    input  logic [5:0]  cfg_dw_addr,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [15:0] io_addr,
    input  logic [15:0] io_wdata,
    output logic [15:0] io_rdata,
    output logic        io_hit,
    input  logic [15:0] evt_in,
    output logic        sci,
    output logic        tmr_arm
);

    logic [15:0]      win_base;
    logic             win_en;
    win_acc_t         acc;
    logic [TMR_W-1:0] tmr_count;
    logic             tmr_ovf;
    logic [31:0]      tmr_wide;
    logic [REG_W-1:0] sts;
    logic [REG_W-1:0] en;

    pm_cfg_regs u_cfg (
        .clk        (clk),
        .rst        (rst),
        .cfg_wr     (cfg_wr),
        .cfg_dw_addr(cfg_dw_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .win_base   (win_base),
        .win_en     (win_en)
    );

    pm_win_decode u_dec (
        .clk     (clk),
        .rst     (rst),
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .io_addr (io_addr),
        .io_wdata(io_wdata),
        .win_base(win_base),
        .win_en  (win_en),
        .io_hit  (io_hit),
        .acc     (acc)
    );

    pm_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .count     (tmr_count),
        .msb_toggle(tmr_ovf)
    );

    pm_evt_regs u_evt (
        .clk    (clk),
        .rst    (rst),
        .acc    (acc),
        .evt_in (evt_in),
        .tmr_ovf(tmr_ovf),
        .sts    (sts),
        .en     (en),
        .sci    (sci),
        .tmr_arm(tmr_arm)
    );

    assign tmr_wide = 32'(tmr_count);

    always_comb begin
        io_rdata = '0;
        if (acc.rd) begin
            case (acc.sel)
                SEL_STS:    io_rdata = sts;
                SEL_EN:     io_rdata = en;
                SEL_TMR_LO: io_rdata = tmr_wide[15:0];
                SEL_TMR_HI: io_rdata = tmr_wide[31:16];
                default:    io_rdata = '0;
            endcase
        end
    end

    // R7: the interrupt needs an enabled source among the four
    p_sci_source_r7: assert property (@(posedge clk) disable iff (rst)
        sci |-> ((en & SCI_SRC_MASK) != '0) && ((sts & SCI_SRC_MASK) != '0));

    // R10: arming excludes a pending timer status
    p_tmr_arm_r10: assert property (@(posedge clk) disable iff (rst)
        tmr_arm |-> !sts[BIT_TMR] && en[BIT_TMR]);

    // R3: a miss returns zero data
    p_miss_zero_r3: assert property (@(posedge clk) disable iff (rst)
        !io_hit |-> io_rdata == 16'd0);

endmodule

// File: tb/tb_pm_evt_sci.sv
`timescale 1ns/1ps
module tb_pm_evt_sci;

    localparam int          TW   = 12;
    localparam logic [15:0] BASE = 16'hEE00;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_dw_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [15:0] io_addr = '0;
    logic [15:0] io_wdata = '0;
    logic [15:0] io_rdata;
    logic        io_hit;
    logic [15:0] evt_in = '0;
    logic        sci;
    logic        tmr_arm;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    pm_evt_sci #(.TMR_W(TW)) dut (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_dw_addr(cfg_dw_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .io_hit(io_hit),
        .evt_in(evt_in), .sci(sci), .tmr_arm(tmr_arm)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_dw_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        #1;
    endtask

    task automatic cfg_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_dw_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic io_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        #1;
    endtask

    task automatic io_read(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #1 d = io_rdata;
        io_rd = 1'b0;
    endtask

    task automatic pulse_evt(input logic [15:0] m);
        @(negedge clk);
        evt_in = m;
        @(negedge clk);
        evt_in = '0;
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] c;
        logic [15:0] v;
        check("R1 sci", 32'(sci), 0);
        check("R1 tmr_arm", 32'(tmr_arm), 0);
        cfg_read(6'h10, c); check("R1 cfg 0x40", c, 0);
        cfg_read(6'h12, c); check("R1 cfg 0x48", c, 32'h1);
        cfg_read(6'h20, c); check("R1 cfg 0x80", c, 0);
        @(negedge clk); io_addr = 16'h0000; #1;
        check("R1 window off", 32'(io_hit), 0);
        io_read(16'h0002, v); check("R1 enable read", 32'(v), 0);
    endtask

    task automatic t_window();
        logic [31:0] c;
        logic [15:0] v;
        cfg_write(6'h10, 32'h0000_EE3F);
        cfg_read(6'h10, c); check("R2 base readback", c, 32'h0000_EE3F);
        @(negedge clk); io_addr = BASE; #1;
        check("R3 disabled hit", 32'(io_hit), 0);
        cfg_write(6'h20, 32'h1);
        @(negedge clk); io_addr = BASE; #1;          check("R2 low edge", 32'(io_hit), 1);
        @(negedge clk); io_addr = BASE + 16'h3F; #1; check("R2 high edge", 32'(io_hit), 1);
        @(negedge clk); io_addr = BASE - 16'h1; #1;  check("R2 below", 32'(io_hit), 0);
        @(negedge clk); io_addr = BASE + 16'h40; #1; check("R2 above", 32'(io_hit), 0);
        cfg_write(6'h20, 32'h0);
        io_write(BASE + 16'h2, 16'h0100);
        io_read(BASE + 16'h2, v); check("R3 read while off", 32'(v), 0);
        cfg_write(6'h20, 32'h1);
        io_read(BASE + 16'h2, v); check("R3 write ignored", 32'(v), 0);
        io_write(BASE + 16'h4, 16'hFFFF);
        io_read(BASE + 16'h4, v); check("R6 unused offset", 32'(v), 0);
        io_read(BASE + 16'h2, v); check("R6 unused write ignored", 32'(v), 0);
    endtask

    task automatic t_status();
        logic [15:0] v;
        pulse_evt(16'h0100);
        io_read(BASE, v); check("R4 event sets", 32'(v & 16'hFFFE), 32'h0100);
        io_write(BASE, 16'h0000);
        io_read(BASE, v); check("R5 write 0 no effect", 32'(v & 16'hFFFE), 32'h0100);
        io_write(BASE, 16'h0100);
        io_read(BASE, v); check("R5 write 1 clears", 32'(v & 16'hFFFE), 0);
        @(negedge clk);
        evt_in = 16'h0100; io_addr = BASE; io_wdata = 16'h0100; io_wr = 1'b1;
        @(negedge clk);
        evt_in = '0; io_wr = 1'b0;
        io_read(BASE, v); check("R5 set wins over clear", 32'(v & 16'hFFFE), 32'h0100);
    endtask

    task automatic t_sci();
        logic [15:0] v;
        io_write(BASE + 16'h2, 16'h0100);
        io_read(BASE + 16'h2, v); check("R6 enable readback", 32'(v), 32'h0100);
        check("R7 sci pwrbtn", 32'(sci), 1);
        io_write(BASE + 16'h2, 16'h0000);
        check("R8 drop on enable clear", 32'(sci), 0);
        io_write(BASE, 16'hFFFE);
        io_write(BASE + 16'h2, 16'h0002);
        pulse_evt(16'h0002);
        check("R7 non-source bit", 32'(sci), 0);
        io_write(BASE, 16'h0002);
        for (int k = 0; k < 3; k++) begin
            logic [15:0] b;
            b = (k == 0) ? 16'h0020 : (k == 1) ? 16'h0100 : 16'h0400;
            io_write(BASE + 16'h2, b);
            check("R7 pre-event", 32'(sci), 0);
            pulse_evt(b);
            check("R7 source asserts", 32'(sci), 1);
            repeat (3) @(negedge clk);
            #1 check("R8 level holds", 32'(sci), 1);
            io_write(BASE, b);
            check("R8 drop on status clear", 32'(sci), 0);
        end
        io_write(BASE + 16'h2, 16'h0000);
    endtask

    task automatic t_timer();
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] v;
        int          guard;
        io_write(BASE + 16'h2, 16'h0001);
        for (int r = 0; r < 2; r++) begin
            io_read(BASE, v);
            if (v[0]) io_write(BASE, 16'h0001);
        end
        check("R10 armed", 32'(tmr_arm), 1);
        check("R7 timer not yet", 32'(sci), 0);
        @(negedge clk);
        io_addr = BASE + 16'h8; io_rd = 1'b1;
        #1 a = io_rdata;
        @(negedge clk);
        #1 b = io_rdata;
        check("R9 step by one", 32'(b - a), 1);
        guard = 0;
        while (((io_rdata & 16'h07FF) != 16'h07FF) && guard < 5000) begin
            @(negedge clk); #1; guard++;
        end
        check("R9 status clear before toggle", 32'(sci), 0);
        check("R10 armed before toggle", 32'(tmr_arm), 1);
        @(negedge clk); #1;
        check("R9 count after toggle", 32'(io_rdata & 16'h07FF), 0);
        check("R7 timer sci", 32'(sci), 1);
        check("R10 disarmed", 32'(tmr_arm), 0);
        io_rd = 1'b0;
        io_read(BASE, v); check("R9 status bit 0", 32'(v[0]), 1);
        io_read(BASE + 16'hA, v); check("R9 upper word", 32'(v), 0);
        io_write(BASE, 16'h0001);
        check("R8 drop after timer clear", 32'(sci), 0);
        io_write(BASE + 16'h2, 16'h0000);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_window();
        t_status();
        t_sci();
        t_timer();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule